// File: doc/BRIEF.md
# Thermal Foldback Dimming Controller

This block protects a lighting power stage from overheating. It receives coarse 8-bit temperature codes, where a larger code means a hotter sensor. Each code passes through two smoothing stages in series. The first is fast and the second is slow. The smoothed code then drives two actions. The first is a dimming reduction that rises in proportion to how far the code sits above a programmable foldback point. The second is a thermal fault latch with hysteresis, which turns the converter off when the code gets too hot and turns it back on only after the code has cooled below a separate, lower wake-up point. For scale, a code near 197 corresponds to about 95 °C and a code near 242 to about 125 °C. The defaults for the foldback, wake-up and shutdown points are 200, 220 and 240.

Samples enter on a valid/ready stream. Results leave on a second valid/ready stream. A sample is taken on a cycle where `s_valid` and `s_ready` are both high. A result is taken on a cycle where `m_valid` and `m_ready` are both high. While `m_ready` is low, the result is held unchanged. A second sample can wait inside the block, and after that `s_ready` falls until the downstream side accepts the held result. Every accepted sample produces exactly one result, in the same order as the samples. The configuration inputs are plain levels. They are expected to stay steady while results are in flight.

Top module: `thermal_foldback`

## Requirements
- R1: After reset, `m_valid` is 0, `fault` is 0, `conv_en` is 1 and `s_ready` is 1.
- R2: The first sample accepted after reset loads both smoothing stages with that code. Its result therefore reports `m_temp` equal to the input code.
- R3: After the first sample, each stage updates as acc += (target − acc) >>> k, using an arithmetic shift. Each accumulator holds 8 fraction bits. The fast stage targets the input code and takes k = `tc_fast`. The slow stage targets the fast stage's new accumulator and takes k = `tc_slow`. `m_temp` is the integer part of the slow accumulator, and k = 0 passes the target straight through.
- R4: The reduction is (m_temp − fold_thr) × step when m_temp > fold_thr, and 0 otherwise. The step is set by `rate_sel`: 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32.
- R5: The reduction saturates at 4095. With no fault, `m_dim_level` + `m_dim_adj` = 4095 always, so the level never goes below 0.
- R6: When `clamp_en` is 1 and the reduction is nonzero, `m_dim_adj` is limited to the range [sat_lo×16, sat_hi×16]. A zero reduction stays 0.
- R7: A result with m_temp ≥ `shut_thr` sets `fault`. While `fault` is set, `m_dim_level` is 0 and `conv_en` is 0, and `m_dim_adj` still reports the reduction.
- R8: A set fault persists through results with m_temp ≥ `wake_thr`. It clears on the first result with m_temp < `wake_thr`, or on reset.
- R9: With `otp_dis` = 1, results carry `m_dim_adj` = 0 and `m_dim_level` = 4095, and `fault` is 0.
- R10: `m_valid` and the result fields stay stable while `m_ready` is low. With one result held and one sample waiting, `s_ready` is 0. Each accepted sample yields one result, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Temperature sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_code | input | 8 | Coarse temperature code |
| otp_dis | input | 1 | 1 bypasses foldback and shutdown |
| fold_thr | input | 8 | Foldback start code |
| wake_thr | input | 8 | Fault release code |
| shut_thr | input | 8 | Fault trip code |
| rate_sel | input | 2 | Reduction step select |
| tc_fast | input | 3 | Fast stage shift |
| tc_slow | input | 3 | Slow stage shift |
| clamp_en | input | 1 | Enable reduction clamp |
| sat_lo | input | 8 | Lower clamp code |
| sat_hi | input | 8 | Upper clamp code |
| m_valid | output | 1 | Result valid |
| m_ready | input | 1 | Downstream takes result |
| m_temp | output | 8 | Smoothed temperature code |
| m_dim_adj | output | 12 | Dim reduction |
| m_dim_level | output | 12 | Resulting dim level |
| conv_en | output | 1 | Converter enable |
| fault | output | 1 | Thermal fault latched |

## Verification
Some properties are checked on every cycle. A result must hold while it is stalled. Level and reduction must add up to full scale when there is no fault. A held fault must force the level to zero and must imply a code at or above the wake-up point. A hot result must trip the fault. A clamped reduction must stay inside its window. Bypass must suppress all of this.

Other behaviour can only be shown by the bench scenarios. These are the exact smoothing trajectories under different shifts, the seeding on the first sample, each step rate, and the ordered walk through the hysteresis band. They also include result ordering under random back-pressure.

// File: rtl/thermfold_pkg.sv
package thermfold_pkg;
  localparam int TC_W = 3;

  typedef enum logic [1:0] {
    STEP_X4  = 2'd0,
    STEP_X8  = 2'd1,
    STEP_X16 = 2'd2,
    STEP_X32 = 2'd3
  } rate_e;

  localparam int STEP_SHIFT_MIN = 2;
  localparam int STEP_SHIFT_MAX = STEP_SHIFT_MIN + 3;

  function automatic int step_shift(rate_e r);
    return STEP_SHIFT_MIN + int'(r);
  endfunction
endpackage

// File: rtl/tf_ema.sv
// One exponential smoothing stage with a fixed-point accumulator.
module tf_ema #(
  parameter int AW      = 16,
  parameter int SHIFT_W = 3,
  parameter int OUT_LSB = 0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  prime,
  input  logic [AW-1:0]         target,
  input  logic [SHIFT_W-1:0]    shift,
  output logic [AW-1:OUT_LSB]   acc_nx
);
  logic [AW-1:0]        acc_q;
  logic [AW-1:0]        acc_sum;
  logic signed [AW:0]   diff;
  logic signed [AW:0]   delta;

  always_comb begin
    diff    = $signed({1'b0, target}) - $signed({1'b0, acc_q});
    delta   = diff >>> shift;
    acc_sum = prime ? target : acc_q + delta[AW-1:0];
  end

  assign acc_nx = acc_sum[AW-1:OUT_LSB];

  always_ff @(posedge clk) begin
    if (!rst_n)     acc_q <= '0;
    else if (load)  acc_q <= acc_sum;
  end
endmodule

// File: rtl/tf_foldback.sv
// Linear reduction above the foldback point, saturated and optionally clamped.
module tf_foldback
  import thermfold_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int DIM_W  = 12
) (
  input  logic [CODE_W-1:0] temp,
  input  logic [CODE_W-1:0] thr,
  input  rate_e             rate,
  input  logic              clamp_en,
  input  logic [CODE_W-1:0] sat_lo,
  input  logic [CODE_W-1:0] sat_hi,
  input  logic              bypass,
  output logic [DIM_W-1:0]  adj
);
  localparam int RAW_W  = CODE_W + STEP_SHIFT_MAX + 1;
  localparam int PROD_W = (RAW_W > DIM_W + 1) ? RAW_W : DIM_W + 1;
  localparam logic [PROD_W-1:0] DIM_FULL = PROD_W'({DIM_W{1'b1}});

  logic [CODE_W-1:0] over;
  logic [PROD_W-1:0] prod;
  logic [DIM_W-1:0]  raw;
  logic [DIM_W-1:0]  lo_s, hi_s;
  logic [DIM_W-1:0]  clamped;

  generate
    if (DIM_W >= CODE_W) begin : g_scale_up
      assign lo_s = DIM_W'(sat_lo) << (DIM_W - CODE_W);
      assign hi_s = DIM_W'(sat_hi) << (DIM_W - CODE_W);
    end else begin : g_scale_down
      assign lo_s = sat_lo[CODE_W-1 -: DIM_W];
      assign hi_s = sat_hi[CODE_W-1 -: DIM_W];
    end
  endgenerate

  always_comb begin
    over = (temp > thr) ? temp - thr : '0;
    prod = PROD_W'(over) << step_shift(rate);
    raw  = (prod > DIM_FULL) ? DIM_FULL[DIM_W-1:0] : prod[DIM_W-1:0];
    if (!clamp_en || raw == '0) clamped = raw;
    else if (raw < lo_s)        clamped = lo_s;
    else if (raw > hi_s)        clamped = hi_s;
    else                        clamped = raw;
    adj = bypass ? '0 : clamped;
  end
endmodule

// File: rtl/tf_fault_latch.sv
// Hysteretic shutdown latch: trips at the shutdown point, releases below wake-up.
module tf_fault_latch #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              bypass,
  input  logic [CODE_W-1:0] temp,
  input  logic [CODE_W-1:0] shut_thr,
  input  logic [CODE_W-1:0] wake_thr,
  output logic              fault_nx,
  output logic              fault_q
);
  always_comb begin
    if (bypass)                          fault_nx = 1'b0;
    else if (temp >= shut_thr)           fault_nx = 1'b1;
    else if (fault_q && temp >= wake_thr) fault_nx = 1'b1;
    else                                 fault_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   fault_q <= 1'b0;
    else if (upd) fault_q <= fault_nx;
  end
endmodule

// File: rtl/thermal_foldback.sv
module thermal_foldback
  import thermfold_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int FRAC_W = 8,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [CODE_W-1:0] s_code,
  input  logic              otp_dis,
  input  logic [CODE_W-1:0] fold_thr,
  input  logic [CODE_W-1:0] wake_thr,
  input  logic [CODE_W-1:0] shut_thr,
  input  logic [1:0]        rate_sel,
  input  logic [TC_W-1:0]   tc_fast,
  input  logic [TC_W-1:0]   tc_slow,
  input  logic              clamp_en,
  input  logic [CODE_W-1:0] sat_lo,
  input  logic [CODE_W-1:0] sat_hi,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [CODE_W-1:0] m_temp,
  output logic [DIM_W-1:0]  m_dim_adj,
  output logic [DIM_W-1:0]  m_dim_level,
  output logic              conv_en,
  output logic              fault
);
  localparam int AW = CODE_W + FRAC_W;
  localparam logic [DIM_W-1:0] DIM_FULL = {DIM_W{1'b1}};

  logic              take_in;
  logic              adv_out;
  logic              primed_q;
  logic              pv_q;
  logic [CODE_W-1:0] ptemp_q;
  logic [AW-1:0]     acc1_nx;
  logic [CODE_W-1:0] temp2_nx;
  logic [DIM_W-1:0]  adj_c;
  logic              fault_nx;
  logic              fault_q;

  // Two-slot pipeline: smoothed code slot, then result slot.
  assign adv_out = !m_valid || m_ready;
  assign s_ready = !pv_q || adv_out;
  assign take_in = s_valid && s_ready;

  tf_ema #(.AW(AW), .SHIFT_W(TC_W), .OUT_LSB(0)) u_fast (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take_in),
    .prime  (!primed_q),
    .target ({s_code, {FRAC_W{1'b0}}}),
    .shift  (tc_fast),
    .acc_nx (acc1_nx)
  );

  tf_ema #(.AW(AW), .SHIFT_W(TC_W), .OUT_LSB(FRAC_W)) u_slow (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (take_in),
    .prime  (!primed_q),
    .target (acc1_nx),
    .shift  (tc_slow),
    .acc_nx (temp2_nx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed_q <= 1'b0;
      pv_q     <= 1'b0;
      ptemp_q  <= '0;
    end else begin
      if (take_in) begin
        primed_q <= 1'b1;
        pv_q     <= 1'b1;
        ptemp_q  <= temp2_nx;
      end else if (adv_out) begin
        pv_q     <= 1'b0;
      end
    end
  end

  tf_foldback #(.CODE_W(CODE_W), .DIM_W(DIM_W)) u_fold (
    .temp     (ptemp_q),
    .thr      (fold_thr),
    .rate     (rate_e'(rate_sel)),
    .clamp_en (clamp_en),
    .sat_lo   (sat_lo),
    .sat_hi   (sat_hi),
    .bypass   (otp_dis),
    .adj      (adj_c)
  );

  tf_fault_latch #(.CODE_W(CODE_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (pv_q && adv_out),
    .bypass   (otp_dis),
    .temp     (ptemp_q),
    .shut_thr (shut_thr),
    .wake_thr (wake_thr),
    .fault_nx (fault_nx),
    .fault_q  (fault_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid     <= 1'b0;
      m_temp      <= '0;
      m_dim_adj   <= '0;
      m_dim_level <= DIM_FULL;
    end else if (pv_q && adv_out) begin
      m_valid     <= 1'b1;
      m_temp      <= ptemp_q;
      m_dim_adj   <= adj_c;
      m_dim_level <= fault_nx ? '0 : DIM_FULL - adj_c;
    end else if (m_ready) begin
      m_valid     <= 1'b0;
    end
  end

  assign fault   = fault_q;
  assign conv_en = !fault_q;
endmodule

// File: rtl/thermal_foldback_chk.sv
module thermal_foldback_chk #(
  parameter int CODE_W = 8,
  parameter int DIM_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              otp_dis,
  input logic [CODE_W-1:0] wake_thr,
  input logic [CODE_W-1:0] shut_thr,
  input logic              clamp_en,
  input logic [CODE_W-1:0] sat_lo,
  input logic [CODE_W-1:0] sat_hi,
  input logic              m_valid,
  input logic              m_ready,
  input logic [CODE_W-1:0] m_temp,
  input logic [DIM_W-1:0]  m_dim_adj,
  input logic [DIM_W-1:0]  m_dim_level,
  input logic              fault
);
  localparam int SH = DIM_W - CODE_W;

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_temp) && $stable(m_dim_adj) && $stable(m_dim_level));

  p_level_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !fault |-> (DIM_W+1)'(m_dim_level) + (DIM_W+1)'(m_dim_adj) == (DIM_W+1)'({DIM_W{1'b1}}));

  p_clamp_win_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && clamp_en && m_dim_adj != '0 |->
      m_dim_adj >= (DIM_W'(sat_lo) << SH) && m_dim_adj <= (DIM_W'(sat_hi) << SH));

  p_fault_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && fault |-> m_dim_level == '0);

  p_trip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !otp_dis && m_temp >= shut_thr |-> fault);

  p_band_r8: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && fault |-> m_temp >= wake_thr);

  p_bypass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && otp_dis |-> !fault && m_dim_adj == '0);
endmodule

bind thermal_foldback thermal_foldback_chk #(.CODE_W(CODE_W), .DIM_W(DIM_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .otp_dis     (otp_dis),
  .wake_thr    (wake_thr),
  .shut_thr    (shut_thr),
  .clamp_en    (clamp_en),
  .sat_lo      (sat_lo),
  .sat_hi      (sat_hi),
  .m_valid     (m_valid),
  .m_ready     (m_ready),
  .m_temp      (m_temp),
  .m_dim_adj   (m_dim_adj),
  .m_dim_level (m_dim_level),
  .fault       (fault)
);

// File: tb/thermal_foldback_test.sv
module thermal_foldback_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [7:0] s_code = '0;
  logic otp_dis = 1'b0;
  logic [7:0] fold_thr = 8'd200;
  logic [7:0] wake_thr = 8'd220;
  logic [7:0] shut_thr = 8'd240;
  logic [1:0] rate_sel = 2'd3;
  logic [2:0] tc_fast = 3'd0;
  logic [2:0] tc_slow = 3'd0;
  logic clamp_en = 1'b0;
  logic [7:0] sat_lo = 8'd10;
  logic [7:0] sat_hi = 8'd160;
  logic m_valid;
  logic m_ready = 1'b1;
  logic [7:0] m_temp;
  logic [11:0] m_dim_adj;
  logic [11:0] m_dim_level;
  logic conv_en;
  logic fault;

  always #5 clk = ~clk;

  thermal_foldback uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_code(s_code),
    .otp_dis(otp_dis), .fold_thr(fold_thr), .wake_thr(wake_thr), .shut_thr(shut_thr),
    .rate_sel(rate_sel), .tc_fast(tc_fast), .tc_slow(tc_slow), .clamp_en(clamp_en),
    .sat_lo(sat_lo), .sat_hi(sat_hi), .m_valid(m_valid), .m_ready(m_ready),
    .m_temp(m_temp), .m_dim_adj(m_dim_adj), .m_dim_level(m_dim_level),
    .conv_en(conv_en), .fault(fault)
  );

  typedef struct packed {
    logic [7:0]  temp;
    logic [11:0] adj;
    logic [11:0] level;
    logic        flt;
  } exp_t;

  exp_t  sb[$];
  string sb_tag[$];
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  // Reference model state
  int  acc1, acc2;
  bit  primed = 1'b0;
  bit  flt_m  = 1'b0;

  int  bp_mode = 0; // 0 always ready, 1 stalled, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;

  initial forever begin
    @(posedge clk);
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (bp_mode == 0)      m_ready = 1'b1;
    else if (bp_mode == 1) m_ready = 1'b0;
    else                   m_ready = lfsr[3] | lfsr[7];
  end

  task automatic check(input bit ok, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s", msg);
    end
  endtask

  task automatic push_expect(input int code, input string tag);
    exp_t e;
    int t, over, red, lo, hi;
    if (!primed) begin
      acc1 = code * 256;
      acc2 = acc1;
      primed = 1'b1;
    end else begin
      acc1 = acc1 + ((code * 256 - acc1) >>> tc_fast);
      acc2 = acc2 + ((acc1 - acc2) >>> tc_slow);
    end
    t = acc2 / 256;
    over = (t > int'(fold_thr)) ? t - int'(fold_thr) : 0;
    red = over * (4 << rate_sel);
    if (red > 4095) red = 4095;
    if (clamp_en && red != 0) begin
      lo = int'(sat_lo) * 16;
      hi = int'(sat_hi) * 16;
      if (red < lo) red = lo;
      else if (red > hi) red = hi;
    end
    if (otp_dis) begin
      red = 0;
      flt_m = 1'b0;
    end else if (t >= int'(shut_thr)) flt_m = 1'b1;
    else if (!(flt_m && t >= int'(wake_thr))) flt_m = 1'b0;
    e.temp  = 8'(t);
    e.adj   = 12'(red);
    e.level = flt_m ? 12'd0 : 12'(4095 - red);
    e.flt   = flt_m;
    sb.push_back(e);
    sb_tag.push_back(tag);
  endtask

  task automatic send(input int code, input string tag);
    @(posedge clk);
    #1;
    s_valid = 1'b1;
    s_code  = 8'(code);
    do @(negedge clk); while (!s_ready);
    push_expect(code, tag);
    @(posedge clk);
    #1;
    s_valid = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    @(posedge clk);
    #1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    primed = 1'b0;
    flt_m  = 1'b0;
  endtask

  // Monitor: compares each delivered result against the scoreboard head.
  initial forever begin
    @(negedge clk);
    if (rst_n && m_valid && m_ready) begin
      if (sb.size() == 0) begin
        check(1'b0, $sformatf("R10 unexpected result temp=%0d expected none", m_temp));
      end else begin
        exp_t  e;
        string tg;
        e  = sb.pop_front();
        tg = sb_tag.pop_front();
        check(m_temp == e.temp && m_dim_adj == e.adj && m_dim_level == e.level &&
              fault == e.flt && conv_en == !e.flt,
              $sformatf("%s temp=%0d adj=%0d level=%0d fault=%0d en=%0d expected temp=%0d adj=%0d level=%0d fault=%0d",
                        tg, m_temp, m_dim_adj, m_dim_level, fault, conv_en,
                        e.temp, e.adj, e.level, e.flt));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(m_valid == 1'b0 && fault == 1'b0 && conv_en == 1'b1 && s_ready == 1'b1,
          $sformatf("R1 valid=%0d fault=%0d en=%0d ready=%0d expected 0 0 1 1",
                    m_valid, fault, conv_en, s_ready));

    // R2 seeding, R4 basic foldback at rate x32
    send(100, "R2");
    send(150, "R4");
    send(200, "R4");
    send(201, "R4");
    send(210, "R4");
    drain();
    rate_sel = 2'd0; send(210, "R4");
    drain();
    rate_sel = 2'd1; send(210, "R4");
    drain();
    rate_sel = 2'd2; send(210, "R4");
    drain();

    // R5 saturation of the reduction
    rate_sel = 2'd3; fold_thr = 8'd100;
    send(239, "R5");
    send(180, "R5");
    drain();

    // R6 clamp window
    clamp_en = 1'b1; fold_thr = 8'd200;
    send(200, "R6");
    send(201, "R6");
    send(210, "R6");
    send(239, "R6");
    drain();
    fold_thr = 8'd150;
    send(239, "R6");
    drain();
    clamp_en = 1'b0; fold_thr = 8'd200;

    // R7 trip, R8 hysteresis band
    send(240, "R7");
    send(230, "R8");
    send(221, "R8");
    send(220, "R8");
    send(219, "R8");
    send(245, "R7");
    send(100, "R8");
    drain();

    // R9 bypass
    otp_dis = 1'b1;
    send(250, "R9");
    send(210, "R9");
    drain();
    otp_dis = 1'b0;

    // R3 smoothing trajectory with nonzero shifts
    do_reset();
    tc_fast = 3'd1; tc_slow = 3'd2;
    send(100, "R2");
    for (int i = 0; i < 6; i++) send(200, "R3");
    send(50, "R3");
    send(255, "R3");
    drain();
    tc_fast = 3'd0; tc_slow = 3'd3;
    send(0, "R3");
    send(255, "R3");
    drain();

    // R10 stall: one held result plus one waiting sample blocks input
    do_reset();
    tc_fast = 3'd0; tc_slow = 3'd0;
    @(posedge clk);
    #1;
    bp_mode = 1;
    repeat (2) @(posedge clk);
    send(120, "R10");
    send(130, "R10");
    @(negedge clk);
    check(s_ready == 1'b0 && m_valid == 1'b1,
          $sformatf("R10 stall ready=%0d valid=%0d expected 0 1", s_ready, m_valid));
    repeat (4) @(negedge clk);
    check(m_temp == 8'd120 && m_valid == 1'b1,
          $sformatf("R10 hold temp=%0d valid=%0d expected 120 1", m_temp, m_valid));
    @(posedge clk);
    #1;
    bp_mode = 2;
    drain();

    // R10 ordering under random back-pressure, with mixed features
    rate_sel = 2'd2; clamp_en = 1'b1;
    for (int i = 0; i < 40; i++) send((i * 37 + 150) % 256, "R10");
    drain();
    bp_mode = 0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, $sformatf("R10 leftover=%0d expected 0", sb.size()));

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule